// File: doc/BRIEF.md
# Flash command interface decoder

This block sits between a host bus and the write engine of a parallel flash device. Every bus write cycle carries an address and a data word whose low byte is taken as a command. The decoder interprets single-cycle commands that choose what a read returns (array contents, status, identifier data or the query table), and it interprets two-cycle sequences that launch program or erase jobs. A job is handed to the write engine as a one-cycle start pulse with its kind, address, data and word count. The engine answers with a done pulse and an error flag.

A status byte reports readiness and sticky error flags that only a clear command removes. While a job runs, the command set shrinks to status reads and a suspend request. An enhanced-program job ignores every write until it completes. A malformed sequence, such as a wrong confirm byte or an oversized buffer count, sets both error flags and leaves the read path in status mode. The buffered path only counts the words and forwards each one as a push pulse; the storage behind it lives elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read mode is array (code 0), status reads 0x80 (ready, no errors), and no start, push or suspend pulse is active.
- R2: In idle, command 0xFF selects read mode 0 (array), 0x70 mode 1 (status), 0x90 mode 2 (identifier) and 0x98 mode 3 (query), one cycle after the write.
- R3: Status bit 4 is the program error flag and bit 5 the erase error flag. A done pulse with the engine error flag set raises bit 5 for an erase job and bit 4 for any other job. Only command 0x50 in idle clears both bits.
- R4: Command 0x40 followed by any write starts a word-program job (kind 0) that carries the second write's address and data. Status bit 7 reads 0 while the job runs and the read mode becomes status.
- R5: Command 0x20 followed by 0xD0 starts an erase job (kind 2) at the address of the confirm write.
- R6: Command 0x20 followed by any byte other than 0xD0 sets status bits 5 and 4, selects status mode and starts no job.
- R7: Command 0xE8 is followed by a write that carries the word count minus one, then that many words. Each word gives one push pulse with the word on buf_word. A following 0xD0 starts a buffered job (kind 1) with job_count equal to the count minus one. Any other confirm byte sets bits 5 and 4 and starts no job.
- R8: A buffered count word of 512 or more sets bits 5 and 4, selects status mode and produces no push pulse.
- R9: While a word-program, buffered or erase job runs, only 0x70 (status mode) and 0xB0 (one-cycle suspend request pulse) have an effect. Every other command leaves the read mode and the status bits unchanged and raises no error.
- R10: A done pulse ends the job and sets status bit 7 to 1. The read mode stays on status until 0xFF is written.
- R11: Command 0x80 followed by 0xD0 starts an enhanced-program job (kind 3). While it runs, every write, including 0x70 and 0xB0, is ignored. A confirm byte other than 0xD0 sets bits 5 and 4.
- R12: In idle, a byte that is not a defined command changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | AW | Address of the write cycle |
| wr_data | input | DW | Data of the write cycle; the low byte is the command |
| eng_done | input | 1 | Write engine finished the running job |
| eng_err | input | 1 | Job failed; valid together with eng_done |
| rd_mode | output | 2 | Read mode: 0 array, 1 status, 2 identifier, 3 query |
| status | output | 8 | Status byte: bit 7 ready, bit 5 erase error, bit 4 program error |
| job_start | output | 1 | One-cycle pulse that launches a job |
| job_kind | output | 2 | 0 word program, 1 buffered, 2 erase, 3 enhanced |
| job_addr | output | AW | Job address |
| job_data | output | DW | Word-program data |
| job_count | output | CW | Buffered word count minus one |
| buf_push | output | 1 | One-cycle pulse per buffered word |
| buf_word | output | DW | Word that goes with buf_push |
| susp_req | output | 1 | One-cycle suspend request |

## Verification
Mode selection is tried with every read opcode and with an undefined byte, which shows that decode is exact rather than lenient. Each two-cycle sequence is driven once with its correct second write and once with a wrong one, which separates a job launch from the error path that sets both flags. During busy periods the bench writes opcodes that would otherwise change the mode or clear errors. This shows that the busy filter blocks them, lets status reads and suspend through, and in the enhanced job blocks even those. Engine errors on program and on erase jobs show that each sets its own sticky flag and that only the clear command removes it.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int BUF_WORDS = 512,
  localparam int CW = $clog2(BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          eng_done,
  input  logic          eng_err,
  output logic [1:0]    rd_mode,
  output logic [7:0]    status,
  output logic          job_start,
  output logic [1:0]    job_kind,
  output logic [AW-1:0] job_addr,
  output logic [DW-1:0] job_data,
  output logic [CW-1:0] job_count,
  output logic          buf_push,
  output logic [DW-1:0] buf_word,
  output logic          susp_req
);
  typedef enum logic [2:0] {S_IDLE, S_PROG, S_ERASE, S_BCNT, S_BDATA, S_BCONF, S_ECONF, S_RUN} st_t;
  localparam logic [1:0] M_ARRAY = 2'd0, M_STAT = 2'd1, M_ID = 2'd2, M_QRY = 2'd3;
  localparam logic [1:0] K_WORD = 2'd0, K_BUF = 2'd1, K_ERASE = 2'd2, K_ENH = 2'd3;

  st_t st;
  logic err_p, err_e;
  logic [CW-1:0] rem;
  logic [7:0] cmd;
  logic is_conf;

  assign cmd     = wr_data[7:0];
  assign is_conf = (cmd == 8'hD0);
  assign status  = {st != S_RUN, 1'b0, err_e, err_p, 4'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_mode   <= M_ARRAY;
      err_p     <= 1'b0;
      err_e     <= 1'b0;
      rem       <= '0;
      job_start <= 1'b0;
      job_kind  <= K_WORD;
      job_addr  <= '0;
      job_data  <= '0;
      job_count <= '0;
      buf_push  <= 1'b0;
      buf_word  <= '0;
      susp_req  <= 1'b0;
    end else begin
      job_start <= 1'b0;
      buf_push  <= 1'b0;
      susp_req  <= 1'b0;
      if (st == S_RUN) begin
        if (eng_done) begin
          st <= S_IDLE;
          if (eng_err) begin
            if (job_kind == K_ERASE) err_e <= 1'b1;
            else                     err_p <= 1'b1;
          end
        end else if (wr_en && job_kind != K_ENH) begin
          if (cmd == 8'h70)      rd_mode  <= M_STAT;
          else if (cmd == 8'hB0) susp_req <= 1'b1;
        end
      end else if (wr_en) begin
        case (st)
          S_IDLE: begin
            case (cmd)
              8'hFF: rd_mode <= M_ARRAY;
              8'h70: rd_mode <= M_STAT;
              8'h90: rd_mode <= M_ID;
              8'h98: rd_mode <= M_QRY;
              8'h50: begin err_p <= 1'b0; err_e <= 1'b0; end
              8'h40: begin st <= S_PROG;  rd_mode <= M_STAT; end
              8'h20: begin st <= S_ERASE; rd_mode <= M_STAT; end
              8'hE8: begin st <= S_BCNT;  rd_mode <= M_STAT; end
              8'h80: begin st <= S_ECONF; rd_mode <= M_STAT; end
              default: ;
            endcase
          end
          S_PROG: begin
            st <= S_RUN; job_start <= 1'b1; job_kind <= K_WORD;
            job_addr <= wr_addr; job_data <= wr_data;
          end
          S_BCNT: begin
            if (32'(wr_data) >= BUF_WORDS) begin
              st <= S_IDLE; err_p <= 1'b1; err_e <= 1'b1;
            end else begin
              st <= S_BDATA; rem <= wr_data[CW-1:0]; job_count <= wr_data[CW-1:0];
            end
          end
          S_BDATA: begin
            buf_push <= 1'b1;
            buf_word <= wr_data;
            if (rem == '0) st <= S_BCONF;
            else           rem <= rem - 1'b1;
          end
          S_ERASE, S_BCONF, S_ECONF: begin
            if (is_conf) begin
              st <= S_RUN; job_start <= 1'b1; job_addr <= wr_addr; job_data <= wr_data;
              job_kind <= (st == S_ERASE) ? K_ERASE : (st == S_BCONF) ? K_BUF : K_ENH;
            end else begin
              st <= S_IDLE; err_p <= 1'b1; err_e <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r4_start_in_status: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |-> (rd_mode == M_STAT && !status[7]));

  a_r6_bad_erase_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERASE && wr_en && cmd != 8'hD0) |=> (status[5:4] == 2'b11 && rd_mode == M_STAT && !job_start));

  a_r8_oversize_count: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BCNT && wr_en && 32'(wr_data) >= BUF_WORDS) |=> (!buf_push && st == S_IDLE && status[5:4] == 2'b11));

  a_r9_busy_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && wr_en && !eng_done && cmd != 8'h70) |=> ($stable(rd_mode) && $stable(status[5:4]) && !job_start));

  a_r3_clear_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_p) || $fell(err_e)) |-> $past(st == S_IDLE && wr_en && cmd == 8'h50));

  a_r11_enhanced_no_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && job_kind == K_ENH) |=> !susp_req);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({job_start, buf_push, susp_req}));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int AW = 24, DW = 16, CW = 9;

  logic clk = 0, rst_n = 0, wr_en = 0, eng_done = 0, eng_err = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] rd_mode, job_kind;
  logic [7:0] status;
  logic job_start, buf_push, susp_req;
  logic [AW-1:0] job_addr;
  logic [DW-1:0] job_data, buf_word;
  logic [CW-1:0] job_count;

  always #5 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_done(eng_done), .eng_err(eng_err), .rd_mode(rd_mode), .status(status),
    .job_start(job_start), .job_kind(job_kind), .job_addr(job_addr), .job_data(job_data),
    .job_count(job_count), .buf_push(buf_push), .buf_word(buf_word), .susp_req(susp_req));

  typedef struct {
    int due; int rq;
    logic [1:0] mode; logic [7:0] st; logic js; logic [1:0] kind; logic bp; logic sp; logic [23:0] x;
  } exp_t;

  exp_t q[$];
  exp_t it;
  int cyc = 0, checks = 0, errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      it = q.pop_front();
      check(it.rq, "rd_mode", 32'(rd_mode), 32'(it.mode));
      check(it.rq, "status", 32'(status), 32'(it.st));
      check(it.rq, "job_start", 32'(job_start), 32'(it.js));
      check(it.rq, "buf_push", 32'(buf_push), 32'(it.bp));
      check(it.rq, "susp_req", 32'(susp_req), 32'(it.sp));
      if (it.js) begin
        check(it.rq, "job_kind", 32'(job_kind), 32'(it.kind));
        check(it.rq, "job_addr", 32'(job_addr), 32'(it.x));
      end
      if (it.bp) check(it.rq, "buf_word", 32'(buf_word), 32'(it.x));
    end
  end

  task automatic step(input bit w, input logic [23:0] a, input logic [15:0] d, input bit dn, input bit er,
                      input int rq, input logic [1:0] m, input logic [7:0] st,
                      input bit js, input logic [1:0] k, input bit bp, input bit sp, input logic [23:0] x);
    exp_t e;
    wr_en = w; wr_addr = a; wr_data = d; eng_done = dn; eng_err = er;
    e.due = cyc + 1; e.rq = rq; e.mode = m; e.st = st; e.js = js; e.kind = k; e.bp = bp; e.sp = sp; e.x = x;
    q.push_back(e);
    @(negedge clk);
    wr_en = 0; eng_done = 0; eng_err = 0;
  endtask

  task automatic wr(input logic [23:0] a, input logic [15:0] d, input int rq, input logic [1:0] m,
                    input logic [7:0] st, input bit js, input logic [1:0] k, input bit bp, input bit sp,
                    input logic [23:0] x);
    step(1, a, d, 0, 0, rq, m, st, js, k, bp, sp, x);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(1, "reset rd_mode", 32'(rd_mode), 0);
    check(1, "reset status", 32'(status), 32'h80);
    check(1, "reset pulses", 32'({job_start, buf_push, susp_req}), 0);

    // R2 mode opcodes, R12 undefined byte
    wr(0, 16'h0090, 2, 2, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h0098, 2, 3, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h0070, 2, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h00FF, 2, 0, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h0012, 12, 0, 8'h80, 0, 0, 0, 0, 0);

    // R4 word program, R9 busy filter, R3 engine error, R10 done
    wr(0, 16'h0040, 4, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(24'h100, 16'hBEEF, 4, 1, 8'h00, 1, 0, 0, 0, 24'h100);
    check(4, "job_data", 32'(job_data), 32'hBEEF);
    wr(0, 16'h00FF, 9, 1, 8'h00, 0, 0, 0, 0, 0);
    wr(0, 16'h0090, 9, 1, 8'h00, 0, 0, 0, 0, 0);
    wr(0, 16'h0050, 9, 1, 8'h00, 0, 0, 0, 0, 0);
    wr(0, 16'h00B0, 9, 1, 8'h00, 0, 0, 0, 1, 0);
    wr(0, 16'h0070, 9, 1, 8'h00, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 3, 1, 8'h90, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 10, 1, 8'h90, 0, 0, 0, 0, 0);
    wr(0, 16'h00FF, 10, 0, 8'h90, 0, 0, 0, 0, 0);
    wr(0, 16'h0050, 3, 0, 8'h80, 0, 0, 0, 0, 0);

    // R5 erase with engine error on erase flag
    wr(0, 16'h0020, 5, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(24'h4000, 16'h00D0, 5, 1, 8'h00, 1, 2, 0, 0, 24'h4000);
    step(0, 0, 0, 1, 1, 3, 1, 8'hA0, 0, 0, 0, 0, 0);
    wr(0, 16'h0050, 3, 1, 8'h80, 0, 0, 0, 0, 0);

    // R6 erase with wrong confirm
    wr(0, 16'h00FF, 2, 0, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h0020, 6, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h00FF, 6, 1, 8'hB0, 0, 0, 0, 0, 0);
    wr(0, 16'h0050, 3, 1, 8'h80, 0, 0, 0, 0, 0);

    // R7 buffered program, three words
    wr(0, 16'h00E8, 7, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h0002, 7, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h1111, 7, 1, 8'h80, 0, 0, 1, 0, 24'h1111);
    wr(0, 16'h2222, 7, 1, 8'h80, 0, 0, 1, 0, 24'h2222);
    wr(0, 16'h3333, 7, 1, 8'h80, 0, 0, 1, 0, 24'h3333);
    wr(24'h200, 16'h00D0, 7, 1, 8'h00, 1, 1, 0, 0, 24'h200);
    check(7, "job_count", 32'(job_count), 2);
    step(0, 0, 0, 1, 0, 10, 1, 8'h80, 0, 0, 0, 0, 0);

    // R8 oversize count
    wr(0, 16'h00E8, 8, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h0200, 8, 1, 8'hB0, 0, 0, 0, 0, 0);
    wr(0, 16'h5555, 8, 1, 8'hB0, 0, 0, 0, 0, 0);
    wr(0, 16'h0050, 3, 1, 8'h80, 0, 0, 0, 0, 0);

    // R7 single word then bad confirm
    wr(0, 16'h00E8, 7, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h0000, 7, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'hAAAA, 7, 1, 8'h80, 0, 0, 1, 0, 24'hAAAA);
    wr(0, 16'h0055, 7, 1, 8'hB0, 0, 0, 0, 0, 0);
    wr(0, 16'h0050, 3, 1, 8'h80, 0, 0, 0, 0, 0);

    // R11 enhanced program ignores everything while running
    wr(0, 16'h0080, 11, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(24'h8, 16'h00D0, 11, 1, 8'h00, 1, 3, 0, 0, 24'h8);
    wr(0, 16'h00B0, 11, 1, 8'h00, 0, 0, 0, 0, 0);
    wr(0, 16'h00FF, 11, 1, 8'h00, 0, 0, 0, 0, 0);
    wr(0, 16'h0040, 11, 1, 8'h00, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 10, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h0080, 11, 1, 8'h80, 0, 0, 0, 0, 0);
    wr(0, 16'h0033, 11, 1, 8'hB0, 0, 0, 0, 0, 0);
    wr(0, 16'h0050, 3, 1, 8'h80, 0, 0, 0, 0, 0);

    // R12 undefined byte in status mode
    wr(0, 16'h0077, 12, 1, 8'h80, 0, 0, 0, 0, 0);
    @(negedge clk);
    summary();
  end
endmodule